// File: doc/BRIEF.md
# Oversampled Serial Receiver with Standby Wakeup

This block recovers asynchronous serial characters from a single receive line. A sampling tick running at sixteen times the bit rate paces it. A character is a low start bit, 8 or 9 data bits sent least significant bit first, and one high stop bit. Each bit is judged by majority vote over three samples taken in the middle of the bit period. The recovered word is presented in parallel, together with a data-ready flag, three error flags and an interrupt request.

For multi-drop links the receiver has a standby state that software enters with a one-cycle set request. In standby, completed words are still written to the data output, but the ready flag stays clear and the interrupt is masked. A select input picks how standby ends. In address-mark mode it ends on a character whose top data bit is 1. In idle-line mode it ends when the line has stayed high for one full character time. The receive line and the tick are expected to be synchronous to the block clock already.

Top module: `uart_rx_wake`

## Requirements
- R1: After reset, rxData is 0 and dataReady, noiseErr, frameErr, overrunErr, standby and irq are all 0.
- R2: A bit period is 16 ticks. A start edge is a tick that sees rxLine low when the previous tick saw it high. That tick is tick 1. The start is accepted only if the vote over ticks 8, 9 and 10 is low; otherwise the receiver returns to hunting, and no word, flag or data change results.
- R3: Each data bit is the majority of the samples at ticks 8, 9 and 10 of its period, taken least significant bit first. In 8-bit mode (nineBitMode = 0), rxData[7:0] holds the character and rxData[8] is 0.
- R4: noiseErr is loaded with 1 when the three samples of the start, any data or the stop bit of the loaded word disagree, and with 0 otherwise.
- R5: With nineBitMode = 1, characters carry 9 data bits, and all 9 appear on rxData.
- R6: A word completes on tick (data bits + 1) × 16 + 10 counted from the start edge, which is tick 154 in 8-bit mode and tick 170 in 9-bit mode. Characters sent 3.75 % fast (8-bit) or 3.40 % fast (9-bit) are received with no error flag.
- R7: frameErr is loaded with 1 when the stop bit votes low. The word is still loaded.
- R8: A word that completes while dataReady is set and readAck is low sets overrunErr and leaves rxData, noiseErr, frameErr and dataReady unchanged.
- R9: A readAck pulse clears dataReady and overrunErr. When it falls in the cycle in which a word completes, the new word is loaded, dataReady is set and overrunErr stays clear.
- R10: A wakeReqSet pulse sets standby in the next cycle. A word completing in standby, or in the cycle of wakeReqSet, is loaded without setting dataReady.
- R11: With wakeSelAddr = 1, a word whose top data bit is 1 (bit 7 in 8-bit mode, bit 8 in 9-bit mode) clears standby and sets dataReady as it is loaded. Words with that bit 0 leave standby set.
- R12: With wakeSelAddr = 0, standby clears on the tick that completes (data bits + 2) × 16 consecutive high ticks seen while hunting. A wakeReqSet pulse restarts that count.
- R13: irq is 1 exactly when standby is 0 and dataReady or overrunErr is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous reset, active low |
| sampleTick | input | 1 | One-cycle strobe at 16 times the bit rate |
| rxLine | input | 1 | Serial receive line, idle high |
| nineBitMode | input | 1 | 1 selects 9 data bits, 0 selects 8 |
| wakeSelAddr | input | 1 | 1 selects address-mark wakeup, 0 selects idle-line wakeup |
| wakeReqSet | input | 1 | One-cycle pulse that enters standby |
| readAck | input | 1 | One-cycle pulse that consumes the word and clears dataReady and overrunErr |
| rxData | output | 9 | Last loaded word |
| dataReady | output | 1 | A word is waiting to be consumed |
| noiseErr | output | 1 | Sample disagreement in the loaded word |
| frameErr | output | 1 | Stop bit of the loaded word was low |
| overrunErr | output | 1 | A word was dropped because dataReady was still set |
| standby | output | 1 | Receiver is in standby |
| irq | output | 1 | Receive interrupt request |

## Verification
The collision that matters is a readAck pulse in the same cycle as a word completing. The bench provokes it by placing the pulse on the clock of the stop bit's tick-10 sample, right after an unconsumed word. It expects the new word to be loaded, dataReady to stay set and no overrun, and it compares this against a behavioural model that applies the acknowledge before the completion. A second coincidence, a wakeup and a completion, is covered by address-mark frames in standby: the same frame must both clear standby and raise dataReady.

// File: rtl/uart_rx_wake_pkg.sv
package uart_rx_wake_pkg;

  typedef enum logic {
    HUNT = 1'b0,
    RUN  = 1'b1
  } rxState_e;

  // strobes from the bit-timing control to the datapath
  typedef struct packed {
    logic tick;       // sampling tick this cycle
    logic edgeFound;  // start edge detected while hunting
    logic idleTick;   // tick while hunting with line high
    logic takeA;      // capture first mid-bit sample
    logic takeB;      // capture second mid-bit sample
    logic resolve;    // third sample present: vote now
    logic isStart;    // current bit is the start bit
    logic isData;     // current bit is a data bit
    logic isStop;     // current bit is the stop bit
  } rxStrobe_t;

endpackage

// File: rtl/uart_rx_ctrl.sv
module uart_rx_ctrl
  import uart_rx_wake_pkg::*;
#(
  parameter int OVS      = 16,
  parameter int MAX_DATA = 9
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      sampleTick,
  input  logic      rxLine,
  input  logic      nineBitMode,
  input  logic      voteBit,
  output rxStrobe_t strobe
);

  localparam int CNT_W    = $clog2(OVS);
  localparam int BIT_W    = $clog2(MAX_DATA + 2);
  localparam int SAMP_MID = OVS / 2;

  rxState_e state;
  logic [CNT_W-1:0] rtCnt;
  logic [BIT_W-1:0] bitCnt;
  logic lineLast;

  logic rtWrap;
  logic [CNT_W-1:0] rtNext;
  logic [BIT_W-1:0] bitNext;
  logic [BIT_W-1:0] stopIdx;
  logic running;

  assign running = (state == RUN);
  assign rtWrap  = (rtCnt == CNT_W'(OVS - 1));
  assign rtNext  = rtWrap ? '0 : rtCnt + 1'b1;
  assign bitNext = rtWrap ? bitCnt + 1'b1 : bitCnt;
  assign stopIdx = nineBitMode ? BIT_W'(MAX_DATA + 1) : BIT_W'(MAX_DATA);

  always_comb begin
    strobe           = '0;
    strobe.tick      = sampleTick;
    strobe.edgeFound = sampleTick & ~running & lineLast & ~rxLine;
    strobe.idleTick  = sampleTick & ~running & rxLine;
    strobe.takeA     = sampleTick & running & (rtNext == CNT_W'(SAMP_MID - 1));
    strobe.takeB     = sampleTick & running & (rtNext == CNT_W'(SAMP_MID));
    strobe.resolve   = sampleTick & running & (rtNext == CNT_W'(SAMP_MID + 1));
    strobe.isStart   = (bitNext == '0);
    strobe.isData    = (bitNext != '0) && (bitNext < stopIdx);
    strobe.isStop    = (bitNext == stopIdx);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= HUNT;
      rtCnt    <= '0;
      bitCnt   <= '0;
      lineLast <= 1'b1;
    end else if (sampleTick) begin
      lineLast <= rxLine;
      if (!running) begin
        if (strobe.edgeFound) begin
          state  <= RUN;
          rtCnt  <= '0;
          bitCnt <= '0;
        end
      end else begin
        rtCnt  <= rtNext;
        bitCnt <= bitNext;
        if (strobe.resolve && ((strobe.isStart && voteBit) || strobe.isStop)) begin
          state <= HUNT;
        end
      end
    end
  end

endmodule

// File: rtl/uart_rx_dp.sv
module uart_rx_dp
  import uart_rx_wake_pkg::*;
#(
  parameter int OVS      = 16,
  parameter int MAX_DATA = 9
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                rxLine,
  input  logic                nineBitMode,
  input  logic                wakeSelAddr,
  input  logic                wakeReqSet,
  input  logic                readAck,
  input  rxStrobe_t           strobe,
  output logic                voteBit,
  output logic [MAX_DATA-1:0] rxData,
  output logic                dataReady,
  output logic                noiseErr,
  output logic                frameErr,
  output logic                overrunErr,
  output logic                standby
);

  localparam int IDLE_W = $clog2((MAX_DATA + 2) * OVS + 1);

  logic sampA, sampB;
  logic [MAX_DATA-1:0] shReg;
  logic noiseAcc;
  logic [IDLE_W-1:0] idleCnt;

  logic disagree;
  logic [MAX_DATA-1:0] word;
  logic wordMsb;
  logic frameDone;
  logic addrWake;
  logic idleWake;
  logic readyHeld;
  logic [IDLE_W-1:0] idleNext;
  logic [IDLE_W-1:0] idleLimit;

  assign voteBit  = (sampA & sampB) | (sampA & rxLine) | (sampB & rxLine);
  assign disagree = ~((sampA == sampB) && (sampB == rxLine));

  assign word    = nineBitMode ? shReg : {1'b0, shReg[MAX_DATA-1:1]};
  assign wordMsb = nineBitMode ? word[MAX_DATA-1] : word[MAX_DATA-2];

  assign frameDone = strobe.resolve & strobe.isStop;
  assign addrWake  = frameDone & standby & wakeSelAddr & wordMsb;
  assign readyHeld = dataReady & ~readAck;

  assign idleNext  = (idleCnt == {IDLE_W{1'b1}}) ? idleCnt : idleCnt + 1'b1;
  assign idleLimit = nineBitMode ? IDLE_W'((MAX_DATA + 2) * OVS)
                                 : IDLE_W'((MAX_DATA + 1) * OVS);
  assign idleWake  = strobe.idleTick & standby & ~wakeSelAddr & (idleNext >= idleLimit);

  // mid-bit samples, shift register, noise accumulation
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sampA    <= 1'b1;
      sampB    <= 1'b1;
      shReg    <= '0;
      noiseAcc <= 1'b0;
    end else begin
      if (strobe.takeA) sampA <= rxLine;
      if (strobe.takeB) sampB <= rxLine;
      if (strobe.edgeFound) begin
        noiseAcc <= 1'b0;
      end else if (strobe.resolve && (strobe.isStart || strobe.isData)) begin
        noiseAcc <= noiseAcc | disagree;
      end
      if (strobe.resolve && strobe.isData) begin
        shReg <= {voteBit, shReg[MAX_DATA-1:1]};
      end
    end
  end

  // word register and status flags
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxData     <= '0;
      dataReady  <= 1'b0;
      noiseErr   <= 1'b0;
      frameErr   <= 1'b0;
      overrunErr <= 1'b0;
    end else begin
      if (readAck) begin
        dataReady  <= 1'b0;
        overrunErr <= 1'b0;
      end
      if (frameDone) begin
        if (readyHeld) begin
          overrunErr <= 1'b1;
        end else begin
          rxData    <= word;
          frameErr  <= ~voteBit;
          noiseErr  <= noiseAcc | disagree;
          dataReady <= ~((standby & ~addrWake) | wakeReqSet);
        end
      end
    end
  end

  // standby state and idle-line counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      standby <= 1'b0;
      idleCnt <= '0;
    end else begin
      if (wakeReqSet) begin
        standby <= 1'b1;
      end else if (addrWake || idleWake) begin
        standby <= 1'b0;
      end
      if (wakeReqSet) begin
        idleCnt <= '0;
      end else if (strobe.tick) begin
        idleCnt <= strobe.idleTick ? idleNext : '0;
      end
    end
  end

endmodule

// File: rtl/uart_rx_wake.sv
module uart_rx_wake
  import uart_rx_wake_pkg::*;
#(
  parameter int OVS      = 16,
  parameter int MAX_DATA = 9
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sampleTick,
  input  logic                rxLine,
  input  logic                nineBitMode,
  input  logic                wakeSelAddr,
  input  logic                wakeReqSet,
  input  logic                readAck,
  output logic [MAX_DATA-1:0] rxData,
  output logic                dataReady,
  output logic                noiseErr,
  output logic                frameErr,
  output logic                overrunErr,
  output logic                standby,
  output logic                irq
);

  rxStrobe_t strobe;
  logic voteBit;

  uart_rx_ctrl #(.OVS(OVS), .MAX_DATA(MAX_DATA)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .sampleTick (sampleTick),
    .rxLine     (rxLine),
    .nineBitMode(nineBitMode),
    .voteBit    (voteBit),
    .strobe     (strobe)
  );

  uart_rx_dp #(.OVS(OVS), .MAX_DATA(MAX_DATA)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .rxLine     (rxLine),
    .nineBitMode(nineBitMode),
    .wakeSelAddr(wakeSelAddr),
    .wakeReqSet (wakeReqSet),
    .readAck    (readAck),
    .strobe     (strobe),
    .voteBit    (voteBit),
    .rxData     (rxData),
    .dataReady  (dataReady),
    .noiseErr   (noiseErr),
    .frameErr   (frameErr),
    .overrunErr (overrunErr),
    .standby    (standby)
  );

  assign irq = ~standby & (dataReady | overrunErr);

endmodule

// File: rtl/uart_rx_wake_chk.sv
module uart_rx_wake_chk #(
  parameter int MAX_DATA = 9
) (
  input logic                clk,
  input logic                rstN,
  input logic                sampleTick,
  input logic                readAck,
  input logic                wakeReqSet,
  input logic [MAX_DATA-1:0] rxData,
  input logic                dataReady,
  input logic                overrunErr,
  input logic                standby
);

  // R10
  standby_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    wakeReqSet |=> standby);

  // R10
  ready_blocked_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dataReady) |-> !standby);

  // R9
  ack_clears_ovr_chk: assert property (@(posedge clk) disable iff (!rstN)
    readAck |=> !overrunErr);

  // R8
  ovr_keeps_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overrunErr) |-> $stable(rxData));

  // R6
  done_on_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dataReady) |-> $past(sampleTick));

endmodule

bind uart_rx_wake uart_rx_wake_chk #(.MAX_DATA(MAX_DATA)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .sampleTick(sampleTick),
  .readAck   (readAck),
  .wakeReqSet(wakeReqSet),
  .rxData    (rxData),
  .dataReady (dataReady),
  .overrunErr(overrunErr),
  .standby   (standby)
);

// File: tb/tb_uart_rx_wake.sv
module tb_uart_rx_wake;

  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sampleTick;
  logic rxLine = 1'b1;
  logic nineBitMode = 1'b0;
  logic wakeSelAddr = 1'b0;
  logic wakeReqSet = 1'b0;
  logic readAck = 1'b0;
  logic [8:0] rxData;
  logic dataReady, noiseErr, frameErr, overrunErr, standby, irq;

  int cycleCnt = 0;
  int checks = 0;
  int errors = 0;
  int startCnt = 0;
  int riseCnt = -1;
  logic prevReady = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;
  always @(posedge clk) cycleCnt <= cycleCnt + 1;
  assign sampleTick = (cycleCnt % TICK_DIV) == 0;

  uart_rx_wake dut (
    .clk(clk), .rstN(rstN), .sampleTick(sampleTick), .rxLine(rxLine),
    .nineBitMode(nineBitMode), .wakeSelAddr(wakeSelAddr),
    .wakeReqSet(wakeReqSet), .readAck(readAck), .rxData(rxData),
    .dataReady(dataReady), .noiseErr(noiseErr), .frameErr(frameErr),
    .overrunErr(overrunErr), .standby(standby), .irq(irq)
  );

  // ---------------- behavioural reference model ----------------
  int  mN = 0, mWord = 0, idleC = 0, mData = 0, nb = 8, bIdx = 0, ph = 0, ones = 0;
  bit  mActive = 0, mPrev = 1, s8 = 1, s9 = 1, mNoise = 0, v = 0, d = 0;
  bit  mReady = 0, mNE = 0, mFE = 0, mOvr = 0, mStby = 0, msb = 0;

  always @(posedge clk) begin
    if (!rstN) begin
      mN = 0; mWord = 0; idleC = 0; mData = 0; mActive = 0; mPrev = 1;
      s8 = 1; s9 = 1; mNoise = 0; mReady = 0; mNE = 0; mFE = 0; mOvr = 0; mStby = 0;
    end else begin
      nb = nineBitMode ? 9 : 8;
      if (readAck) begin mReady = 0; mOvr = 0; end
      if (sampleTick) begin
        if (!mActive) begin
          if (mPrev && !rxLine) begin
            mActive = 1; mN = 1; mNoise = 0; mWord = 0; idleC = 0;
          end else if (rxLine) begin
            if (idleC < 1000) idleC = idleC + 1;
            if (idleC >= (nb + 2) * 16 && mStby && !wakeSelAddr) mStby = 0;
          end else begin
            idleC = 0;
          end
        end else begin
          idleC = 0;
          mN = mN + 1;
          bIdx = (mN - 1) / 16;
          ph = (mN - 1) % 16 + 1;
          if (ph == 8) s8 = rxLine;
          if (ph == 9) s9 = rxLine;
          if (ph == 10) begin
            ones = int'(s8) + int'(s9) + int'(rxLine);
            v = (ones >= 2);
            d = (ones != 0) && (ones != 3);
            if (bIdx == 0) begin
              if (v) mActive = 0; else mNoise = mNoise | d;
            end else if (bIdx <= nb) begin
              if (v) mWord = mWord | (1 << (bIdx - 1));
              mNoise = mNoise | d;
            end else begin
              msb = ((mWord >> (nb - 1)) & 1) != 0;
              if (mStby && wakeSelAddr && msb) mStby = 0;
              if (mReady) mOvr = 1;
              else begin
                mData = mWord; mFE = !v; mNE = mNoise | d;
                mReady = !(mStby || wakeReqSet);
              end
              mActive = 0;
            end
          end
        end
        mPrev = rxLine;
      end
      if (wakeReqSet) begin mStby = 1; idleC = 0; end
    end
  end

  // ---------------- checking helpers ----------------
  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cycleCnt);
    end
  endtask

  // per-clock comparison against the model, plus ready-rise timestamp
  always @(negedge clk) begin
    check(rxData == 9'(mData), "R3 model rxData", int'(rxData), mData);
    check(dataReady == mReady, "R10 model dataReady", int'(dataReady), int'(mReady));
    check(noiseErr == mNE, "R4 model noiseErr", int'(noiseErr), int'(mNE));
    check(frameErr == mFE, "R7 model frameErr", int'(frameErr), int'(mFE));
    check(overrunErr == mOvr, "R8 model overrunErr", int'(overrunErr), int'(mOvr));
    check(standby == mStby, "R12 model standby", int'(standby), int'(mStby));
    check(irq == (!mStby && (mReady || mOvr)), "R13 model irq", int'(irq),
          int'(!mStby && (mReady || mOvr)));
    if (dataReady && !prevReady) riseCnt = cycleCnt;
    prevReady = dataReady;
  end

  // watchdog
  always @(posedge clk) begin
    if (cycleCnt > 150000) begin
      errors++;
      $display("FAIL R1 watchdog expired actual=%0d expected=<150000", cycleCnt);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  // bit length = num/den clocks; glitchC/ackC are clock offsets from the start edge (-1 = none)
  task automatic sendFrame(input int word, input int bits, input int num, input int den,
                           input bit stopVal, input int glitchC, input int ackC);
    int total;
    @(negedge clk);
    while (!sampleTick) @(negedge clk);
    startCnt = cycleCnt;
    riseCnt = -1;
    total = (bits + 2) * num / den;
    for (int c = 0; c < total; c++) begin
      int k;
      bit bv;
      k = (c * den) / num;
      if (k == 0) bv = 1'b0;
      else if (k <= bits) bv = ((word >> (k - 1)) & 1) != 0;
      else bv = stopVal;
      rxLine = (c == glitchC) ? !bv : bv;
      readAck = (c == ackC);
      @(negedge clk);
    end
    rxLine = 1'b1;
    readAck = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  task automatic ack();
    @(negedge clk) readAck = 1'b1;
    @(negedge clk) readAck = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulseWake();
    @(negedge clk) wakeReqSet = 1'b1;
    @(negedge clk) wakeReqSet = 1'b0;
  endtask

  task automatic expectWord(input int word, input bit ne, input bit fe, input string req);
    check(rxData == 9'(word), {req, " rxData"}, int'(rxData), word);
    check(dataReady == 1'b1, {req, " dataReady"}, int'(dataReady), 1);
    check(noiseErr == ne, {req, " noiseErr"}, int'(noiseErr), int'(ne));
    check(frameErr == fe, {req, " frameErr"}, int'(frameErr), int'(fe));
    check(irq == 1'b1, {req, " R13 irq"}, int'(irq), 1);
  endtask

  task automatic expectLatency(input int bits, input string req);
    int exp;
    exp = 1 + TICK_DIV * (16 * (bits + 1) + 9);
    check(riseCnt - startCnt == exp, req, riseCnt - startCnt, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(rxData == 9'h0 && !dataReady && !noiseErr && !frameErr, "R1 reset data/flags",
          int'({rxData, dataReady, noiseErr, frameErr}), 0);
    check(!overrunErr && !standby && !irq, "R1 reset ovr/standby/irq",
          int'({overrunErr, standby, irq}), 0);
    rstN = 1'b1;
    repeat (20) @(negedge clk);

    // R3 / R6: 8-bit nominal
    sendFrame(32'hA5, 8, 64, 1, 1'b1, -1, -1);
    expectWord(32'h0A5, 0, 0, "R3 8-bit nominal");
    expectLatency(8, "R6 8-bit completes at tick 154");
    ack();
    check(!dataReady && !irq, "R9 ack clears ready", int'(dataReady), 0);

    // R6: 8-bit 3.75% fast
    sendFrame(32'h3C, 8, 616, 10, 1'b1, -1, -1);
    expectWord(32'h03C, 0, 0, "R6 8-bit fast");
    expectLatency(8, "R6 8-bit fast completion tick");
    ack();

    // R5: 9-bit nominal and 3.40% fast
    nineBitMode = 1'b1;
    sendFrame(32'h1A5, 9, 64, 1, 1'b1, -1, -1);
    expectWord(32'h1A5, 0, 0, "R5 9-bit nominal");
    expectLatency(9, "R6 9-bit completes at tick 170");
    ack();
    sendFrame(32'h0F3, 9, 680, 11, 1'b1, -1, -1);
    expectWord(32'h0F3, 0, 0, "R6 9-bit fast");
    ack();
    nineBitMode = 1'b0;

    // R4: single glitch on tick 9 of data bit 2
    sendFrame(32'h5A, 8, 64, 1, 1'b1, 224, -1);
    expectWord(32'h05A, 1, 0, "R4 noise glitch");
    ack();

    // R7: stop bit low
    sendFrame(32'h81, 8, 64, 1, 1'b0, -1, -1);
    expectWord(32'h081, 0, 1, "R7 framing error");
    ack();

    // R2: short low pulse is not a start
    @(negedge clk);
    while (!sampleTick) @(negedge clk);
    rxLine = 1'b0;
    repeat (8) @(negedge clk);
    rxLine = 1'b1;
    repeat (800) @(negedge clk);
    check(!dataReady && rxData == 9'h081, "R2 false start ignored", int'(rxData), 32'h081);

    // R8: overrun keeps first word
    sendFrame(32'h11, 8, 64, 1, 1'b1, -1, -1);
    sendFrame(32'h22, 8, 64, 1, 1'b1, -1, -1);
    check(overrunErr && dataReady && rxData == 9'h011, "R8 overrun keeps data",
          int'(rxData), 32'h011);
    check(irq == 1'b1, "R13 irq on overrun", int'(irq), 1);
    ack();
    check(!overrunErr && !dataReady, "R9 ack clears overrun", int'(overrunErr), 0);

    // R9: ack in the completion cycle
    sendFrame(32'h55, 8, 64, 1, 1'b1, -1, -1);
    sendFrame(32'h66, 8, 64, 1, 1'b1, -1, TICK_DIV * 153);
    check(rxData == 9'h066 && dataReady && !overrunErr, "R9 ack/complete collision",
          int'({overrunErr, rxData}), 32'h066);
    ack();

    // R10 / R11: address-mark standby
    wakeSelAddr = 1'b1;
    pulseWake();
    @(negedge clk);
    check(standby == 1'b1, "R10 standby entered", int'(standby), 1);
    sendFrame(32'h12, 8, 64, 1, 1'b1, -1, -1);
    check(rxData == 9'h012 && !dataReady && standby, "R10 loaded without ready",
          int'({dataReady, rxData}), 32'h012);
    check(irq == 1'b0, "R13 irq masked in standby", int'(irq), 0);
    sendFrame(32'h85, 8, 64, 1, 1'b1, -1, -1);
    check(!standby && dataReady && rxData == 9'h085, "R11 address mark wakes",
          int'({standby, dataReady, rxData}), 32'h285);
    ack();

    // R12: idle-line standby
    wakeSelAddr = 1'b0;
    pulseWake();
    sendFrame(32'h40, 8, 64, 1, 1'b1, -1, -1);
    check(standby && !dataReady && rxData == 9'h040, "R12 standby holds across frame",
          int'({standby, rxData}), 32'h240);
    repeat (TICK_DIV * 100) @(negedge clk);
    check(standby == 1'b1, "R12 standby before full idle frame", int'(standby), 1);
    pulseWake();
    repeat (TICK_DIV * 100) @(negedge clk);
    check(standby == 1'b1, "R12 wake request restarts idle count", int'(standby), 1);
    repeat (TICK_DIV * 100) @(negedge clk);
    check(standby == 1'b0, "R12 idle line wakes", int'(standby), 0);

    repeat (10) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule